// File: doc/BRIEF.md
# Cascadable Register Magnitude Comparator Slice

This block is one byte-wide slice of a storage-and-compare chain. The slice has a register that can keep its value, take a byte from the data bus, or take one bit at a time from its serial input. In the hold state the register can also be read back onto the bus. In the compare state the slice checks its stored byte against the byte now on the bus. It reports the result on three status lines: greater, equal and less. Each status line behaves as an open-collector output, so a slice that does not drive a line leaves it at logic 1. The lines of all slices in a chain are joined by AND to give one chain-wide result.

Slices are chained through a single cascade pin. In compare, a slice works only when its cascade input is high. An enabled slice that finds its byte equal passes the enable down to the next less significant slice and leaves its own status lines released. An enabled slice that finds a difference keeps the enable from all slices below it and drives the result itself. The least significant slice drives the equal result when every byte above it has matched. In shift, the same pins serve as serial data in and out.

A mode input selects signed or unsigned ordering. Signed ordering affects only the slice that holds the sign bit. All lower slices always compare their bytes as unsigned values.

Top module: `rcmp_slice`

## Requirements
- R1: An asynchronous active-low reset clears the stored byte to zero.
- R2: With `sel` = 01 (load), the stored byte takes the value of `bus_i` on the rising clock edge.
- R3: With `sel` = 00 (hold), the stored byte does not change. `bus_oe` is 1 and `bus_o` shows the stored byte only when `sel` = 00 and `rd_en` = 1. Otherwise `bus_oe` is 0 and `bus_o` is zero.
- R4: With `sel` = 10 (shift), each rising edge moves the stored byte one place toward bit 7 and loads `cs_i` into bit 0. `cs_o` shows the current bit 7.
- R5: With `sel` = 11 (compare) and `cs_i` = 0, `cs_o` is 0 and all three status lines are released (1).
- R6: In compare with `cs_i` = 1 and equal bytes, a slice built with `IS_LSB` = 0 drives `cs_o` to 1 and releases all three status lines.
- R7: In compare with `cs_i` = 1 and unequal bytes, `cs_o` is 0. If the stored byte orders above the bus byte, `cmp_gt` is 1 and the other two lines are 0. If it orders below, `cmp_lt` is 1 and the other two lines are 0.
- R8: With `twos_mode` = 0, bytes are ordered as unsigned values. With `twos_mode` = 1, a slice built with `IS_MSB` = 1 orders bytes as two's-complement values. A slice with `IS_MSB` = 0 always orders them as unsigned values.
- R9: In compare with `cs_i` = 1 and equal bytes, a slice built with `IS_LSB` = 1 drives `cmp_eq` to 1, drives `cmp_gt` and `cmp_lt` to 0, and drives `cs_o` to 1.
- R10: In a chain, each slice's `cs_o` feeds the `cs_i` of the next less significant slice, and the most significant slice has `cs_i` = 1. The AND of all the slices' status lines then gives the greater, equal or less result for the whole multi-byte word.
- R11: Outside compare, all three status lines are released (1). `cs_o` is 0 in hold and in load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 2 | Operation: 00 hold, 01 load, 10 shift, 11 compare |
| rd_en | input | 1 | Drives the stored byte onto the bus while in hold |
| twos_mode | input | 1 | 1 = signed ordering, 0 = unsigned ordering |
| bus_i | input | WIDTH | Data arriving from the bus |
| bus_o | output | WIDTH | Stored byte toward the bus (zero when not driving) |
| bus_oe | output | 1 | Bus drive enable |
| cs_i | input | 1 | Cascade enable in compare, serial data in during shift |
| cs_o | output | 1 | Cascade enable out in compare, serial data out during shift |
| cmp_gt | output | 1 | Greater status, open-collector style (released = 1) |
| cmp_eq | output | 1 | Equal status, open-collector style (released = 1) |
| cmp_lt | output | 1 | Less status, open-collector style (released = 1) |

## Verification
The bench uses `WIDTH` = 8. With that width it can sweep every pair of stored byte and bus byte in both ordering modes, on a single slice built as both most and least significant. This covers the sign boundary between 0x7F and 0x80 and every equal case. A second group of three slices uses the same width and forms a 24-bit word. It is built with `IS_MSB` set only on the top slice and `IS_LSB` set only on the bottom slice. This brings the cascade handoff, the released lines and the wired-AND result into reach. The words tested include ones that differ only in the lowest byte, which makes the enable ripple through the whole chain.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_SHIFT = 2'b10,
    OP_CMP   = 2'b11
  } op_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } stat_t;

  localparam stat_t STAT_FLOAT = 3'b111;
  localparam stat_t STAT_GT    = 3'b100;
  localparam stat_t STAT_EQ    = 3'b010;
  localparam stat_t STAT_LT    = 3'b001;

endpackage

// File: rtl/rcmp_store.sv
module rcmp_store
  import rcmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD:  q <= par_i;
        OP_SHIFT: q <= {q[WIDTH-2:0], ser_i};
        default:  q <= q;
      endcase
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (q == $past(par_i)));                          // R2

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(q));                                   // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHIFT) |=> (q[0] == $past(ser_i)));                      // R4

endmodule

// File: rtl/rcmp_compare.sv
module rcmp_compare #(
  parameter int WIDTH  = 8,
  parameter bit SIGNED_OK = 1'b1
) (
  input  logic [WIDTH-1:0] reg_b,
  input  logic [WIDTH-1:0] bus_b,
  input  logic             twos,
  output logic             above,
  output logic             same
);

  localparam logic SGN_EN = SIGNED_OK;

  // Sort key: flipping the top bit maps two's-complement order onto unsigned order.
  function automatic logic [WIDTH-1:0] order_key(input logic [WIDTH-1:0] v,
                                                 input logic flip);
    return {v[WIDTH-1] ^ flip, v[WIDTH-2:0]};
  endfunction

  logic             flip;
  logic [WIDTH-1:0] key_reg;
  logic [WIDTH-1:0] key_bus;

  assign flip    = twos & SGN_EN;
  assign key_reg = order_key(reg_b, flip);
  assign key_bus = order_key(bus_b, flip);
  assign above   = key_reg > key_bus;
  assign same    = reg_b == bus_b;

endmodule

// File: rtl/rcmp_cascade.sv
module rcmp_cascade
  import rcmp_pkg::*;
#(
  parameter bit LAST = 1'b1
) (
  input  op_e   op,
  input  logic  en_i,
  input  logic  top_bit,
  input  logic  above,
  input  logic  same,
  output logic  en_o,
  output stat_t st
);

  always_comb begin
    st   = STAT_FLOAT;
    en_o = 1'b0;
    case (op)
      OP_SHIFT: en_o = top_bit;
      OP_CMP: begin
        if (en_i) begin
          if (same) begin
            en_o = 1'b1;
            if (LAST) st = STAT_EQ;
          end else begin
            st = above ? STAT_GT : STAT_LT;
          end
        end
      end
      default: en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rcmp_slice.sv
module rcmp_slice
  import rcmp_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit IS_MSB = 1'b1,
  parameter bit IS_LSB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             rd_en,
  input  logic             twos_mode,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe,
  input  logic             cs_i,
  output logic             cs_o,
  output logic             cmp_gt,
  output logic             cmp_eq,
  output logic             cmp_lt
);

  op_e              op;
  logic [WIDTH-1:0] stored;
  logic             cmp_above;
  logic             cmp_same;
  stat_t            status;

  assign op = op_e'(sel);

  rcmp_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .par_i (bus_i),
    .ser_i (cs_i),
    .q     (stored)
  );

  rcmp_compare #(.WIDTH(WIDTH), .SIGNED_OK(IS_MSB)) u_compare (
    .reg_b (stored),
    .bus_b (bus_i),
    .twos  (twos_mode),
    .above (cmp_above),
    .same  (cmp_same)
  );

  rcmp_cascade #(.LAST(IS_LSB)) u_cascade (
    .op      (op),
    .en_i    (cs_i),
    .top_bit (stored[WIDTH-1]),
    .above   (cmp_above),
    .same    (cmp_same),
    .en_o    (cs_o),
    .st      (status)
  );

  assign bus_oe = (op == OP_HOLD) && rd_en;
  assign bus_o  = bus_oe ? stored : '0;
  assign cmp_gt = status.gt;
  assign cmp_eq = status.eq;
  assign cmp_lt = status.lt;

  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_CMP) |-> (cmp_gt && cmp_eq && cmp_lt));                  // R11

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP && !cs_i) |-> (!cs_o && cmp_gt && cmp_eq && cmp_lt)); // R5

  AST_MATCH_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP && cs_i && cmp_same) |-> cs_o);                      // R6

  AST_MISMATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP && cs_i && !cmp_same) |->
      (!cs_o && $countones({cmp_gt, cmp_eq, cmp_lt}) == 1 && !cmp_eq)); // R7

  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHIFT) |-> (cs_o == stored[WIDTH-1]));                   // R4

  AST_READ_HOLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (op == OP_HOLD && bus_o == stored));                    // R3

endmodule

// File: tb/test_rcmp_slice.sv
module test_rcmp_slice;

  localparam int W   = 8;
  localparam int NSL = 3;
  localparam int CW  = W * NSL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // single slice: both most and least significant
  logic [1:0]   s_sel = 2'b00;
  logic         s_rd = 1'b0;
  logic         s_twos = 1'b0;
  logic [W-1:0] s_bus = '0;
  logic [W-1:0] s_bus_o;
  logic         s_oe;
  logic         s_csi = 1'b0;
  logic         s_cso, s_gt, s_eq, s_lt;

  rcmp_slice #(.WIDTH(W), .IS_MSB(1'b1), .IS_LSB(1'b1)) i_rcmp_slice (
    .clk(clk), .rst_n(rst_n), .sel(s_sel), .rd_en(s_rd), .twos_mode(s_twos),
    .bus_i(s_bus), .bus_o(s_bus_o), .bus_oe(s_oe), .cs_i(s_csi), .cs_o(s_cso),
    .cmp_gt(s_gt), .cmp_eq(s_eq), .cmp_lt(s_lt)
  );

  // chain of NSL slices, index NSL-1 most significant
  logic [1:0]   c_sel = 2'b00;
  logic         c_twos = 1'b0;
  logic         c_top = 1'b1;
  logic [CW-1:0] c_word = '0;
  logic [W-1:0] c_bus_o [NSL];
  logic         c_oe  [NSL];
  logic [NSL:0] c_link;
  logic [NSL-1:0] c_gt, c_eq, c_lt;

  assign c_link[NSL] = c_top;

  for (genvar k = 0; k < NSL; k++) begin : g_chain
    rcmp_slice #(.WIDTH(W), .IS_MSB(k == NSL-1), .IS_LSB(k == 0)) i_link (
      .clk(clk), .rst_n(rst_n), .sel(c_sel), .rd_en(1'b0), .twos_mode(c_twos),
      .bus_i(c_word[k*W +: W]), .bus_o(c_bus_o[k]), .bus_oe(c_oe[k]),
      .cs_i(c_link[k+1]), .cs_o(c_link[k]),
      .cmp_gt(c_gt[k]), .cmp_eq(c_eq[k]), .cmp_lt(c_lt[k])
    );
  end

  logic w_gt, w_eq, w_lt;
  assign w_gt = &c_gt;
  assign w_eq = &c_eq;
  assign w_lt = &c_lt;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic gt, input logic eq);
    return gt ? 3'b100 : (eq ? 3'b010 : 3'b001);
  endfunction

  function automatic logic [CW-1:0] mix(input logic [CW-1:0] x);
    logic [CW-1:0] y;
    y = x ^ (x << 7);
    y = y ^ (y >> 5);
    y = y ^ (y << 3);
    return (y == '0) ? CW'(1) : y;
  endfunction

  task automatic solo_load(input logic [W-1:0] v);
    @(negedge clk);
    s_sel = 2'b01;
    s_bus = v;
    @(negedge clk);
    s_sel = 2'b00;
  endtask

  task automatic chain_cmp(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic gt_e, eq_e;
    for (int m = 0; m < 2; m++) begin
      c_twos = m[0];
      c_word = b;
      #1;
      gt_e = m[0] ? ($signed(a) > $signed(b)) : (a > b);
      eq_e = (a == b);
      chk("R10 chain wired result", {29'd0, w_gt, w_eq, w_lt}, {29'd0, exp_stat(gt_e, eq_e)});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0]  sh_model;
    logic [CW-1:0] a, b, seed;
    logic          gt_e;

    // R1 reset state, R3 read and R11 idle status
    s_rd = 1'b1;
    #5;
    chk("R1 reset value", {24'd0, s_bus_o}, 32'd0);
    chk("R11 idle status in reset", {28'd0, s_gt, s_eq, s_lt, s_cso}, 32'hE);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    s_rd = 1'b0;

    // R2 load and R3 read back for every byte, R8/R9/R7 exhaustive compare
    for (int a8 = 0; a8 < 256; a8++) begin
      solo_load(a8[W-1:0]);
      s_rd = 1'b1;
      #1;
      chk("R3 read drives bus", {23'd0, s_oe, s_bus_o}, {23'd0, 1'b1, a8[7:0]});
      chk("R11 hold status", {28'd0, s_gt, s_eq, s_lt, s_cso}, 32'hE);
      @(negedge clk);
      chk("R3 hold keeps byte", {24'd0, s_bus_o}, {24'd0, a8[7:0]});
      s_rd = 1'b0;
      s_sel = 2'b11;
      s_csi = 1'b1;
      for (int b8 = 0; b8 < 256; b8++) begin
        for (int m = 0; m < 2; m++) begin
          s_twos = m[0];
          s_bus = b8[W-1:0];
          #1;
          gt_e = m[0] ? ($signed(a8[7:0]) > $signed(b8[7:0])) : (a8[7:0] > b8[7:0]);
          chk("R7 R8 R9 single slice compare", {28'd0, s_gt, s_eq, s_lt, s_cso},
              {28'd0, exp_stat(gt_e, a8 == b8), (a8 == b8)});
        end
      end
      // R5 disabled compare
      s_csi = 1'b0;
      s_bus = ~a8[W-1:0];
      #1;
      chk("R5 disabled slice", {28'd0, s_gt, s_eq, s_lt, s_cso}, 32'hE);
      s_bus = a8[W-1:0];
      #1;
      chk("R5 disabled slice equal", {28'd0, s_gt, s_eq, s_lt, s_cso}, 32'hE);
      // R3 read ignored outside hold
      @(negedge clk);
      s_sel = 2'b01;
      s_rd = 1'b1;
      s_bus = a8[W-1:0];
      #1;
      chk("R3 no drive in load", {23'd0, s_oe, s_bus_o}, 32'd0);
      chk("R11 load status", {28'd0, s_gt, s_eq, s_lt, s_cso}, 32'hE);
      s_rd = 1'b0;
      s_sel = 2'b00;
      s_twos = 1'b0;
    end

    // R4 shift: serial in at bit 0, bit 7 out
    solo_load(8'hA5);
    sh_model = 8'hA5;
    seed = 24'h3C_5A_91;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      s_sel = 2'b10;
      s_csi = seed[i];
      #1;
      chk("R4 serial out", {31'd0, s_cso}, {31'd0, sh_model[W-1]});
      sh_model = {sh_model[W-2:0], seed[i]};
    end
    @(negedge clk);
    s_sel = 2'b00;
    s_rd = 1'b1;
    #1;
    chk("R4 shifted contents", {24'd0, s_bus_o}, {24'd0, sh_model});
    s_rd = 1'b0;

    // R6 non-LSB equal releases and passes on; R10 chain sweep
    seed = 24'hB1_7E_42;
    for (int t = 0; t < 200; t++) begin
      seed = mix(seed);
      a = seed;
      if (t == 0) a = 24'h80_00_00;
      if (t == 1) a = 24'h7F_FF_FF;
      @(negedge clk);
      c_sel = 2'b01;
      c_word = a;
      @(negedge clk);
      c_sel = 2'b11;
      c_word = a;
      c_twos = 1'b0;
      #1;
      chk("R6 upper slice equal releases", {29'd0, c_gt[NSL-1], c_eq[NSL-1], c_lt[NSL-1]}, 32'h7);
      chk("R6 upper slice passes enable", {31'd0, c_link[NSL-1]}, 32'd1);
      chk_chain_all(a, seed);
      c_sel = 2'b00;
    end

    // R10 with top enable low: whole chain quiet
    @(negedge clk);
    c_sel = 2'b11;
    c_top = 1'b0;
    c_word = 24'h00_00_01;
    #1;
    chk("R10 chain disabled", {29'd0, w_gt, w_eq, w_lt}, 32'h7);
    c_top = 1'b1;
    c_sel = 2'b00;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic chk_chain_all(input logic [CW-1:0] a, input logic [CW-1:0] s);
    logic [CW-1:0] r;
    r = mix(s ^ 24'h5A_5A_5A);
    chain_cmp(a, a);
    chain_cmp(a, a ^ 24'h00_00_01);
    chain_cmp(a, a ^ 24'h00_00_80);
    chain_cmp(a, a ^ 24'h00_01_00);
    chain_cmp(a, a ^ 24'h80_00_00);
    chain_cmp(a, a ^ 24'h40_00_00);
    chain_cmp(a, {a[CW-1:W], r[W-1:0]});
    chain_cmp(a, {a[CW-1:CW-W], r[CW-W-1:0]});
    chain_cmp(a, r);
  endtask

endmodule